// File: doc/BRIEF.md
# Packed Sub-Word Saturating ALU

A 32-bit media arithmetic unit that treats each operand as a group of small lanes and works on all lanes at once. The datapath is made of four 8-bit adder slices. A single width select either isolates every slice (four 8-bit lanes) or links slices in pairs (two 16-bit lanes) by letting the carry out of the lower slice of a pair feed the upper one.

Each lane can add or subtract with a modular result, or clamp the result at the unsigned or signed limits of the lane. Two packed compares, equality and signed greater-than, fill each lane with all ones when the condition holds and with all zeros when it does not. The result is registered once, so an operation presented in one cycle appears on the output after the next rising edge, and a new operation may be presented every cycle.

Top module: `pkalu`

## Requirements
- R1: While reset (rst_n low) is applied, the result output reads 0 after each rising clock edge.
- R2: With op = 0 (add) or 1 (subtract), wide = 0 and sat = 0, each of the four bytes (bits 8k+7..8k) holds the byte sum or difference modulo 256, and no carry or borrow reaches the neighbouring byte.
- R3: With op = 0 or 1, wide = 1 and sat = 0, bits 15..0 and bits 31..16 each hold the 16-bit sum or difference modulo 65536, with the carry linked across the byte border inside each half.
- R4: With wide = 0 and sat = 1 (unsigned clamp), a byte lane result that would exceed 0xFF is 0xFF and one that would go below 0x00 is 0x00.
- R5: With wide = 0 and sat = 2 (signed clamp), a byte lane result, with lanes read as two's complement, above 0x7F is 0x7F and below 0x80 is 0x80.
- R6: With wide = 1, sat = 1 clamps each 16-bit lane to 0x0000..0xFFFF and sat = 2 clamps it to 0x8000..0x7FFF (signed).
- R7: With op = 2 (equal), each lane (8-bit or 16-bit as set by wide) is all ones when the two source lanes are equal and all zeros otherwise.
- R8: With op = 3 (greater), each lane is all ones when the first source lane is greater than the second, both read as two's complement, and all zeros otherwise.
- R9: The sat input has no effect on compare results (op = 2 or 3).
- R10: The result of an operation appears after exactly one rising clock edge, not before, and a different operation may follow in every cycle.
- R11: sat = 3 gives the same modular result as sat = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | 0 add, 1 subtract, 2 equal compare, 3 signed greater compare |
| wide_i | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| sat_i | input | 2 | 0 or 3 modular, 1 unsigned clamp, 2 signed clamp |
| src_a_i | input | 32 | First packed operand |
| src_b_i | input | 32 | Second packed operand |
| result_o | output | 32 | Registered packed result |

## Verification
Directed vectors place carries and borrows right at the byte border so that an 8-bit lane that leaks a carry and a 16-bit lane that fails to pass one both show up. Operands at 0x00, 0x7F, 0x80 and 0xFF (and their 16-bit counterparts) separate unsigned from signed clamping and catch a clamp at the wrong end. Seeded random operands over every op, width and saturation setting then exercise mixed lanes where some clamp and some do not, and compares run with every saturation value to show that setting is ignored.

// File: rtl/pkalu_pkg.sv
package pkalu_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_CMPEQ = 2'd2,
        OP_CMPGT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SAT_WRAP  = 2'd0,
        SAT_UNS   = 2'd1,
        SAT_SGN   = 2'd2,
        SAT_WRAP2 = 2'd3
    } sat_e;

endpackage

// File: rtl/pkalu_slice.sv
module pkalu_slice #(
    parameter int SLICE_W = 8
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  logic               cin_i,
    output logic [SLICE_W-1:0] sum_o,
    output logic               cout_o
);
    logic [SLICE_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, cin_i};
        sum_o    = wide_sum[SLICE_W-1:0];
        cout_o   = wide_sum[SLICE_W];
    end
endmodule

// File: rtl/pkalu_lane.sv
module pkalu_lane
    import pkalu_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [1:0]        sat_i,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  logic [LANE_W-1:0] sum_i,
    input  logic              cout_i,
    output logic [LANE_W-1:0] res_o
);
    localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};

    logic is_sub, is_cmp, a_m, b_m, s_m, sovf, uovf, zero, lt;

    always_comb begin
        is_sub = (op_i != OP_ADD);
        is_cmp = op_i[1];
        a_m    = a_i[LANE_W-1];
        b_m    = b_i[LANE_W-1];
        s_m    = sum_i[LANE_W-1];
        sovf   = is_sub ? ((a_m != b_m) && (s_m != a_m))
                        : ((a_m == b_m) && (s_m != a_m));
        uovf   = is_sub ? !cout_i : cout_i;
        zero   = (sum_i == '0);
        lt     = s_m ^ sovf;
        res_o  = sum_i;
        if (is_cmp) begin
            if (op_i == OP_CMPEQ) res_o = {LANE_W{zero}};
            else                  res_o = {LANE_W{!zero && !lt}};
        end else begin
            case (sat_i)
                SAT_UNS: if (uovf) res_o = is_sub ? '0 : '1;
                SAT_SGN: if (sovf) res_o = a_m ? SMIN : SMAX;
                default: res_o = sum_i;
            endcase
        end
    end

    // R4 / R6: an unsigned clamped add never falls below its first operand
    assert_usat_add_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD && sat_i == SAT_UNS) |-> (res_o >= a_i));

    // R4 / R6: an unsigned clamped subtract never rises above its first operand
    assert_usat_sub_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB && sat_i == SAT_UNS) |-> (res_o <= a_i));

    // R5 / R6: signed clamped add of two non-negative lanes stays non-negative
    assert_ssat_add_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD && sat_i == SAT_SGN && !a_i[LANE_W-1] && !b_i[LANE_W-1])
        |-> !res_o[LANE_W-1]);
endmodule

// File: rtl/pkalu.sv
module pkalu
    import pkalu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic              wide_i,
    input  logic [1:0]        sat_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int NSLICE = DATA_W / SLICE_W;
    localparam int NWIDE  = NSLICE / 2;
    localparam int WIDE_W = 2 * SLICE_W;

    typedef struct packed {
        logic [DATA_W-1:0] result;
    } state_t;

    state_t st_d, st_q;

    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    logic [NSLICE-1:0] cout;
    logic [NSLICE-1:0] cin;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] wide_res;

    assign is_sub = (op_i != OP_ADD);
    assign b_eff  = is_sub ? ~src_b_i : src_b_i;

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        // odd slices take the lower neighbour's carry when lanes are wide
        if (i % 2 == 1) begin : g_link
            assign cin[i] = wide_i ? cout[i-1] : is_sub;
        end else begin : g_head
            assign cin[i] = is_sub;
        end
        pkalu_slice #(.SLICE_W(SLICE_W)) u_slice (
            .a_i   (src_a_i[i*SLICE_W +: SLICE_W]),
            .b_i   (b_eff[i*SLICE_W +: SLICE_W]),
            .cin_i (cin[i]),
            .sum_o (sum[i*SLICE_W +: SLICE_W]),
            .cout_o(cout[i])
        );
        pkalu_lane #(.LANE_W(SLICE_W)) u_blane (
            .clk   (clk),
            .rst_n (rst_n),
            .op_i  (op_i),
            .sat_i (sat_i),
            .a_i   (src_a_i[i*SLICE_W +: SLICE_W]),
            .b_i   (src_b_i[i*SLICE_W +: SLICE_W]),
            .sum_i (sum[i*SLICE_W +: SLICE_W]),
            .cout_i(cout[i]),
            .res_o (byte_res[i*SLICE_W +: SLICE_W])
        );
    end

    for (genvar j = 0; j < NWIDE; j++) begin : g_wide
        pkalu_lane #(.LANE_W(WIDE_W)) u_wlane (
            .clk   (clk),
            .rst_n (rst_n),
            .op_i  (op_i),
            .sat_i (sat_i),
            .a_i   (src_a_i[j*WIDE_W +: WIDE_W]),
            .b_i   (src_b_i[j*WIDE_W +: WIDE_W]),
            .sum_i (sum[j*WIDE_W +: WIDE_W]),
            .cout_i(cout[2*j+1]),
            .res_o (wide_res[j*WIDE_W +: WIDE_W])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.result = wide_i ? wide_res : byte_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;

    // ---------------- assertions ----------------
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0));

    assert_byte_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i == OP_ADD && !wide_i && sat_i == SAT_WRAP))
        |-> (result_o[SLICE_W-1:0] ==
             $past(src_a_i[SLICE_W-1:0] + src_b_i[SLICE_W-1:0])));

    assert_wide_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i == OP_ADD && wide_i && sat_i == SAT_WRAP))
        |-> (result_o[WIDE_W-1:0] ==
             $past(src_a_i[WIDE_W-1:0] + src_b_i[WIDE_W-1:0])));

    for (genvar k = 0; k < NSLICE; k++) begin : g_mask_chk
        assert_cmp_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(op_i[1]))
            |-> (result_o[k*SLICE_W +: SLICE_W] == '0 ||
                 result_o[k*SLICE_W +: SLICE_W] == '1));
    end
endmodule

// File: tb/pkalu_tb.sv
module pkalu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [1:0]  sat_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [31:0] result_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkalu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i), .sat_i(sat_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .result_o(result_o)
    );

    function automatic logic [31:0] ref_model(logic [31:0] a, logic [31:0] b,
                                               logic [1:0] op, logic wide, logic [1:0] sat);
        int          w = wide ? 16 : 8;
        int          n = 32 / w;
        longint      umax = (longint'(1) << w) - 1;
        longint      smax = (longint'(1) << (w - 1)) - 1;
        longint      smin = -(longint'(1) << (w - 1));
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) begin
            longint x = longint'((a >> (i*w)) & umax);
            longint y = longint'((b >> (i*w)) & umax);
            longint xs = (x > smax) ? x - (umax + 1) : x;
            longint ys = (y > smax) ? y - (umax + 1) : y;
            longint v;
            if (op == 2'd2)      v = (x == y) ? umax : 0;
            else if (op == 2'd3) v = (xs > ys) ? umax : 0;
            else if (sat == 2'd1) begin
                v = (op == 2'd0) ? x + y : x - y;
                if (v > umax) v = umax;
                if (v < 0)    v = 0;
            end else if (sat == 2'd2) begin
                v = (op == 2'd0) ? xs + ys : xs - ys;
                if (v > smax) v = smax;
                if (v < smin) v = smin;
                v = v & umax;
            end else begin
                v = ((op == 2'd0) ? x + y : x - y) & umax;
            end
            r = r | (32'(v) << (i*w));
        end
        return r;
    endfunction

    function automatic string req_tag(logic [1:0] op, logic wide, logic [1:0] sat);
        if (op == 2'd2) return (sat == 2'd0) ? "R7" : "R9";
        if (op == 2'd3) return (sat == 2'd0) ? "R8" : "R9";
        if (sat == 2'd3) return "R11";
        if (sat == 2'd0) return wide ? "R3" : "R2";
        if (wide) return "R6";
        return (sat == 2'd1) ? "R4" : "R5";
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: result %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // drive at the falling edge, check at the following falling edge
    task automatic run_op(logic [1:0] op, logic wide, logic [1:0] sat,
                          logic [31:0] a, logic [31:0] b);
        op_i = op; wide_i = wide; sat_i = sat; src_a_i = a; src_b_i = b;
        @(negedge clk);
        check(req_tag(op, wide, sat), result_o, ref_model(a, b, op, wide, sat));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: result %h expected completion", result_o);
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        src_a_i = 32'hFFFF_FFFF; src_b_i = 32'h0101_0101;
        repeat (3) @(negedge clk);
        check("R1", result_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: nothing appears before the edge, result after exactly one edge
        op_i = 2'd0; wide_i = 1'b0; sat_i = 2'd0;
        src_a_i = 32'h1122_3344; src_b_i = 32'h0101_0101;
        @(posedge clk);
        #1;
        check("R10", result_o, 32'h1223_3445);
        src_a_i = 32'h0000_0010; src_b_i = 32'h0000_0001; op_i = 2'd1;
        @(negedge clk);
        check("R10", result_o, 32'h1223_3445);
        @(negedge clk);
        check("R10", result_o, 32'h0000_000F);

        // R2: carry and borrow stop at byte borders
        run_op(2'd0, 1'b0, 2'd0, 32'h00FF_00FF, 32'h0001_0001);
        check("R2", result_o, 32'h0000_0000);
        run_op(2'd1, 1'b0, 2'd0, 32'h0100_0100, 32'h0001_0001);
        check("R2", result_o, 32'h01FF_01FF);
        // R3: carry and borrow cross the byte border inside a half
        run_op(2'd0, 1'b1, 2'd0, 32'h00FF_FFFF, 32'h0001_0001);
        check("R3", result_o, 32'h0100_0000);
        run_op(2'd1, 1'b1, 2'd0, 32'h0100_0000, 32'h0001_0001);
        check("R3", result_o, 32'h00FF_FFFF);
        // R4: unsigned byte clamp
        run_op(2'd0, 1'b0, 2'd1, 32'hFF80_10FE, 32'h0190_2003);
        check("R4", result_o, 32'hFFFF_30FF);
        run_op(2'd1, 1'b0, 2'd1, 32'h0010_0580, 32'h0120_0101);
        check("R4", result_o, 32'h0000_047F);
        // R5: signed byte clamp
        run_op(2'd0, 1'b0, 2'd2, 32'h7F80_7F05, 32'h01FF_8003);
        check("R5", result_o, 32'h7F80_FF08);
        run_op(2'd1, 1'b0, 2'd2, 32'h807F_0000, 32'h01FF_8001);
        check("R5", result_o, 32'h807F_7FFF);
        // R6: 16-bit clamps
        run_op(2'd0, 1'b1, 2'd1, 32'hFFFF_1234, 32'h0001_0001);
        check("R6", result_o, 32'hFFFF_1235);
        run_op(2'd1, 1'b1, 2'd1, 32'h0000_0005, 32'h0001_0001);
        check("R6", result_o, 32'h0000_0004);
        run_op(2'd0, 1'b1, 2'd2, 32'h7FFF_8000, 32'h0001_FFFF);
        check("R6", result_o, 32'h7FFF_8000);
        // R7 / R8: compares at byte and word width
        run_op(2'd2, 1'b0, 2'd0, 32'h1234_5678, 32'h1235_5677);
        check("R7", result_o, 32'hFF00_FF00);
        run_op(2'd2, 1'b1, 2'd0, 32'h1234_5678, 32'h1234_5679);
        check("R7", result_o, 32'hFFFF_0000);
        run_op(2'd3, 1'b0, 2'd0, 32'h7F80_0501, 32'h807F_0501);
        check("R8", result_o, 32'hFF00_0000);
        run_op(2'd3, 1'b1, 2'd0, 32'h0001_8000, 32'hFFFF_7FFF);
        check("R8", result_o, 32'hFFFF_0000);
        // R9: clamp setting does not affect compares
        run_op(2'd3, 1'b0, 2'd1, 32'h7F80_0501, 32'h807F_0501);
        check("R9", result_o, 32'hFF00_0000);
        run_op(2'd2, 1'b0, 2'd2, 32'h1234_5678, 32'h1235_5677);
        check("R9", result_o, 32'hFF00_FF00);
        // R11: setting 3 wraps
        run_op(2'd0, 1'b0, 2'd3, 32'hFF7F_00FF, 32'h0101_0001);
        check("R11", result_o, 32'h0080_0000);

        // seeded random, back to back every cycle (R10), all modes
        for (int i = 0; i < NRAND; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            if (i % 5 == 0) b = a;
            if (i % 7 == 0) a[7:0] = 8'h80;
            run_op(2'($urandom), 1'($urandom), 2'($urandom), a, b);
        end
        finish_run();
    end
endmodule